// File: doc/BRIEF.md
# Sleep-Capable 16-bit Timer/Counter

The block is a 16-bit up-counter that software sees as two byte registers. It counts either every system clock or the rising edges of an external clock pin. When the count goes from FFFFh to 0000h it sets an overflow flag. The flag stays set until software writes it to zero.

The interrupt request is the overflow flag gated by three enables: the timer's own enable, the peripheral-group enable and the global enable. A separate wake output lets a sleeping core resume on overflow without the global enable. Counting while asleep is possible only in asynchronous external-counter mode. In that mode the pin is sampled by a single register instead of the two-flop synchronizer.

In external mode, counting is armed only after a falling edge has been seen on the pin since the timer was last started. This stops a level that is already high at start-up from being taken as a count edge.

Top module: `tmr16_wake`

## Requirements
- R1: With run set and the internal source selected, the count increments by one on every clock edge. A step from FFFFh to 0000h sets the overflow flag.
- R2: `irq` is high exactly when the flag and all three enables are set. The enables sit at address 4: bit 0 is the timer enable, bit 1 the peripheral-group enable and bit 2 the global enable.
- R3: The flag stays set until a bus write puts 0 in bit 0 of address 3. Writing 1 sets the flag. If an overflow and a clearing write fall in the same cycle, the flag stays set.
- R4: In external mode, a rising pin edge is counted only if a falling edge has been seen since run was last set. Clearing run discards that armed state.
- R5: In synchronous external mode, the pin passes through two flops, so the count changes on the third clock edge after the pin rises. In asynchronous mode it changes on the second clock edge.
- R6: While `sleep` is high the count holds, except in asynchronous external mode, where it keeps counting.
- R7: `wake` is high exactly when `sleep`, run, the timer enable, the peripheral-group enable and the flag are all set. The global enable does not affect it.
- R8: A write to a count byte takes effect on the next clock edge and replaces any increment in that cycle.
- R9: Reset clears the count, the flag, the control bits and the enables. Address 0 holds the low count byte and address 1 the high count byte. Address 2 holds the controls: bit 0 run, bit 1 external source, bit 2 asynchronous. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_clk | input | 1 | External count clock pin |
| sleep | input | 1 | Core is asleep |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request to the sleeping core |

## Verification
The bench starts random counts near the top of the range, runs them for random lengths and checks that the count and the flag match the wrap arithmetic. A design that misses or doubles the wrap fails this check.

Directed cases cover the following faults:
- a rising edge before the first falling edge, which a design without arming would count;
- a restart of the timer, which would leave a stale arm behind;
- the exact synchronizer latency, where an extra or a missing stage would show;
- a clearing write that lands on an overflow, which would lose the flag;
- sleep in the synchronous modes, where counting must stop;
- wake with the global enable clear, which a design that gates wake with `irq` would block.

// File: rtl/tmr16_wake.sv
module tmr16_wake #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ext_clk,
  input  logic          sleep,
  output logic          irq,
  output logic          wake
);
  localparam logic [AW-1:0] A_LO   = AW'(0);
  localparam logic [AW-1:0] A_HI   = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);
  localparam logic [AW-1:0] A_EN   = AW'(4);

  logic [15:0] cnt;
  logic flag, run, ext_m, async_m, tie, pe, ge;
  logic s1, s2, prev, armed;

  wire sel  = async_m ? s1 : s2;
  wire rise = sel & ~prev;
  wire fall = ~sel & prev;

  wire wr_lo   = bus_we & (bus_addr == A_LO);
  wire wr_hi   = bus_we & (bus_addr == A_HI);
  wire wr_ctrl = bus_we & (bus_addr == A_CTRL);
  wire wr_flag = bus_we & (bus_addr == A_FLAG);
  wire wr_en   = bus_we & (bus_addr == A_EN);

  wire may_run = ~sleep | (ext_m & async_m);
  wire inc     = run & may_run & (ext_m ? (rise & armed) : 1'b1);
  wire ovf     = inc & (&cnt) & ~wr_lo & ~wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0; armed <= 1'b0;
    end else begin
      s1    <= ext_clk;
      s2    <= s1;
      prev  <= sel;
      armed <= run & (armed | fall);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_lo | wr_hi) begin
      if (wr_lo) cnt[7:0]  <= bus_wdata;
      if (wr_hi) cnt[15:8] <= bus_wdata;
    end else if (inc) begin
      cnt <= cnt + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      {async_m, ext_m, run} <= '0;
      {ge, pe, tie} <= '0;
    end else begin
      if (ovf)          flag <= 1'b1;
      else if (wr_flag) flag <= bus_wdata[0];
      if (wr_ctrl) {async_m, ext_m, run} <= bus_wdata[2:0];
      if (wr_en)   {ge, pe, tie} <= bus_wdata[2:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO:    bus_rdata = cnt[7:0];
      A_HI:    bus_rdata = cnt[15:8];
      A_CTRL:  bus_rdata = {5'b0, async_m, ext_m, run};
      A_FLAG:  bus_rdata = {7'b0, flag};
      A_EN:    bus_rdata = {5'b0, ge, pe, tie};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq  = flag & tie & pe & ge;
  assign wake = sleep & run & tie & pe & flag;
endmodule

// File: rtl/tmr16_wake_chk.sv
module tmr16_wake_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          sleep,
  input logic [15:0]   cnt,
  input logic          flag,
  input logic          run,
  input logic          ext_m,
  input logic          async_m,
  input logic          armed,
  input logic          inc,
  input logic          ge,
  input logic          irq,
  input logic          wake
);
  wire cnt_wr  = bus_we && (bus_addr == AW'(0) || bus_addr == AW'(1));
  wire flag_wr = bus_we && (bus_addr == AW'(3));

  // R1
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt == 16'hFFFF && !cnt_wr) |=> (cnt == 16'h0000 && flag));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_wr) |=> flag);

  // R4
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ext_m && !armed && !cnt_wr) |=> $stable(cnt));

  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !(ext_m && async_m) && !cnt_wr) |=> $stable(cnt));

  // R7
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (sleep && flag && run));

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ge));
endmodule

bind tmr16_wake tmr16_wake_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .sleep(sleep), .cnt(cnt), .flag(flag), .run(run), .ext_m(ext_m),
  .async_m(async_m), .armed(armed), .inc(inc), .ge(ge),
  .irq(irq), .wake(wake)
);

// File: tb/tb_tmr16_wake.sv
`timescale 1ns/100ps
module tb_tmr16_wake;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ext_clk = 1'b0, sleep = 1'b0;
  logic irq, wake;
  int checks = 0, bad = 0;

  always #2.5 clk = ~clk;

  tmr16_wake dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .sleep(sleep), .irq(irq), .wake(wake)
  );

  function automatic logic exp_irq(logic f, logic [2:0] en);
    return f & (en == 3'b111);
  endfunction

  function automatic logic [16:0] exp_cnt(logic [15:0] start, int n);
    return {1'b0, start} + 17'(n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi); c = {hi, lo};
  endtask

  task automatic rd_flag(output logic f);
    logic [7:0] d;
    rd(3'd3, d); f = d[0];
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  task automatic pin(logic v);
    ext_clk = v; repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [15:0] c, c0;
    logic [7:0] d;
    logic f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state and unused address
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R9 reset read", d, 0);
    end
    check("R9 irq/wake at reset", {irq, wake}, 0);

    // R1 constrained random internal counting
    for (int i = 0; i < 12; i++) begin
      logic [15:0] st;
      int n;
      logic [16:0] e;
      st = ($urandom % 2) ? 16'hFFFF - 16'($urandom % 12) : 16'($urandom);
      n = $urandom % 20;
      wr(3'd2, 8'h00); wr(3'd3, 8'h00); set_cnt(st);
      wr(3'd2, 8'h01);
      repeat (n) @(negedge clk);
      e = exp_cnt(st, n);
      rd_cnt(c); rd_flag(f);
      check("R1 count", c, e[15:0]);
      check("R1 flag", f, e[16]);
    end

    // R2 gating of irq, every enable combination
    wr(3'd2, 8'h00); wr(3'd3, 8'h01);
    for (int en = 0; en < 8; en++) begin
      wr(3'd4, 8'(en));
      check("R2 irq gate", irq, exp_irq(1'b1, 3'(en)));
    end
    wr(3'd3, 8'h00);
    check("R2 irq flag clear", irq, 0);

    // R3 flag holds, clear loses to simultaneous overflow
    wr(3'd4, 8'h00);
    set_cnt(16'hFFFF); wr(3'd2, 8'h01);
    repeat (5) @(negedge clk);
    rd_flag(f); check("R3 flag held", f, 1);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    rd_flag(f); check("R3 flag cleared", f, 0);
    wr(3'd3, 8'h01);
    set_cnt(16'hFFFF); wr(3'd2, 8'h01);
    wr(3'd3, 8'h00);
    rd_flag(f); check("R3 clear vs overflow", f, 1);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R8 write overrides increment
    set_cnt(16'h1205); wr(3'd2, 8'h01);
    wr(3'd0, 8'h10);
    rd_cnt(c); check("R8 write override", c, 16'h1210);
    wr(3'd2, 8'h00);

    // R4 arming in synchronous external mode
    set_cnt(16'h0000); ext_clk = 1'b0;
    wr(3'd2, 8'h03);
    pin(1'b1); rd_cnt(c); check("R4 rise before fall", c, 0);
    pin(1'b0); pin(1'b1); rd_cnt(c); check("R4 armed count", c, 1);
    pin(1'b0); wr(3'd2, 8'h00); wr(3'd2, 8'h03);
    pin(1'b1); rd_cnt(c); check("R4 restart disarms", c, 1);
    pin(1'b0); pin(1'b1); rd_cnt(c); check("R4 re-armed", c, 2);

    // R5 synchronous latency
    pin(1'b0); rd_cnt(c0);
    ext_clk = 1'b1;
    repeat (2) @(negedge clk); rd_cnt(c); check("R5 sync early", c, c0);
    @(negedge clk); rd_cnt(c); check("R5 sync third edge", c, c0 + 16'd1);
    pin(1'b1);

    // R5 asynchronous latency
    wr(3'd2, 8'h00); wr(3'd2, 8'h07);
    pin(1'b0); rd_cnt(c0);
    ext_clk = 1'b1;
    @(negedge clk); rd_cnt(c); check("R5 async early", c, c0);
    @(negedge clk); rd_cnt(c); check("R5 async second edge", c, c0 + 16'd1);
    pin(1'b1);

    // R6 sleep holds internal counting
    wr(3'd2, 8'h00); pin(1'b0);
    wr(3'd2, 8'h01); sleep = 1'b1;
    @(negedge clk); rd_cnt(c0);
    repeat (8) @(negedge clk); rd_cnt(c);
    check("R6 sleep internal hold", c, c0);
    sleep = 1'b0;

    // R6 sleep holds synchronous external counting
    wr(3'd2, 8'h00); wr(3'd2, 8'h03);
    pin(1'b1); pin(1'b0); set_cnt(16'h0005);
    sleep = 1'b1;
    pin(1'b1); pin(1'b0); pin(1'b1);
    rd_cnt(c); check("R6 sleep sync hold", c, 5);
    sleep = 1'b0;
    pin(1'b0); pin(1'b1);
    rd_cnt(c); check("R6 count after sleep", c, 6);

    // R6 asynchronous mode counts in sleep; R7 wake without global enable
    wr(3'd2, 8'h00); pin(1'b0); wr(3'd3, 8'h00);
    wr(3'd4, 8'h03); set_cnt(16'hFFFF);
    wr(3'd2, 8'h07);
    pin(1'b1); pin(1'b0);
    sleep = 1'b1;
    pin(1'b1);
    rd_cnt(c); check("R6 async counts asleep", c, 0);
    check("R7 wake raised", wake, 1);
    check("R2 no irq without global", irq, 0);
    wr(3'd4, 8'h01);
    check("R7 wake needs group enable", wake, 0);
    wr(3'd4, 8'h03);
    sleep = 1'b0;
    @(negedge clk);
    check("R7 wake drops awake", wake, 0);
    wr(3'd4, 8'h07);
    check("R2 irq after wake", irq, 1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule